// File: doc/BRIEF.md
# Configurable Ratio Input Deserializer Gearbox

This block turns a fast serial bit stream into parallel words for slower core logic. One bit per lane is taken on every rising edge of the fast clock. The bits are collected into a staging word, and each finished word is copied into an output register together with a one-cycle valid strobe. The slow side is modelled inside the fast domain: a word counter sets the ratio, and the valid strobe marks the slow-side transfer.

A mode input sets the ratio while reset is held. It can build 7-bit words, 8-bit words, or two independent 4-bit lanes that share one output word. The core can request a word-boundary slip. Each accepted request discards one incoming bit, so the boundary moves by one position.

Top module: `gbx_deser`

## Requirements
- R1: With mode_i = 1 the block emits one 8-bit word for every 8 bits taken from data_i[0]. The earliest bit of the word lands in q_o[0], and each later bit fills the next higher position.
- R2: With mode_i = 0 the block emits one word for every 7 bits taken from data_i[0]. These bits fill q_o[6:0] with the earliest bit in q_o[0], and q_o[7] is always 0.
- R3: With mode_i = 2 the block emits a word after every 4 edges. q_o[7:4] holds the 4 bits taken from data_i[0], and q_o[3:0] holds the 4 bits taken from data_i[1]. In each nibble the earliest bit is in the lowest position.
- R4: valid_o is high for exactly one cycle. That cycle follows the edge that captured the last bit of a word. q_o changes only on that edge and holds its value at all other times.
- R5: When slip_i is high on an edge and no earlier slip is still outstanding, the bits presented on that edge are discarded. The current word then completes one edge later than it would have done.
- R6: After a slip has been accepted, further slip_i pulses have no effect until the next word has been emitted.
- R7: While rst_ni is low, q_o is 0 and valid_o is 0. After reset is released, the first valid_o comes only once a full word of bits has been taken.
- R8: The code mode_i = 3 behaves exactly like mode_i = 1.
- R9: In modes 0, 1 and 3, data_i[1] has no effect on q_o or valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Ratio select: 0 = 1:7, 1 = 1:8, 2 = dual 1:4, 3 = same as 1 (change only while reset is held) |
| data_i | input | 2 | Serial bits: [0] is lane A (the only lane in modes 0, 1 and 3), [1] is lane B |
| slip_i | input | 1 | Word-boundary slip request |
| q_o | output | 8 | Parallel output word |
| valid_o | output | 1 | One-cycle strobe marking a new q_o |

## Verification
The hardest case to reach is a slip request that lands on the edge that would have completed a word. A second hard case is a slip pulse that arrives while an earlier slip is still outstanding, because only the second one must be ignored. The stimulus covers these by issuing slips at every counter phase in turn. It also issues back-to-back and closely spaced slip pairs in all three ratios. A reference model built on bit queues is compared with the outputs after every edge.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic [1:0] {
    GBX_NARROW = 2'd0,
    GBX_WIDE   = 2'd1,
    GBX_SPLIT  = 2'd2,
    GBX_RSVD   = 2'd3
  } gbx_mode_e;
endpackage

// File: rtl/gbx_word_ctl.sv
module gbx_word_ctl
  import gbx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int LANES  = 2,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gbx_mode_e        mode_i,
  input  logic             slip_i,
  output logic             take_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam int LEN_N = WORD_W - 1;
  localparam int LEN_S = WORD_W / LANES;

  logic [CNT_W-1:0] cnt_q, len;
  logic             blocked_q, accept_slip;

  always_comb begin
    unique case (mode_i)
      GBX_NARROW: len = CNT_W'(LEN_N);
      GBX_SPLIT:  len = CNT_W'(LEN_S);
      default:    len = CNT_W'(WORD_W);
    endcase
  end

  assign accept_slip = slip_i & ~blocked_q;
  assign take_o      = ~accept_slip;
  assign last_o      = take_o && (cnt_q == len - CNT_W'(1));
  assign idx_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
    end else begin
      if (take_o) cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
      // one slip outstanding at a time; cleared by the emitting edge
      if (accept_slip)  blocked_q <= 1'b1;
      else if (last_o)  blocked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gbx_stage.sv
module gbx_stage
  import gbx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int LANES  = 2,
  localparam int CNT_W  = $clog2(WORD_W + 1),
  localparam int LANE_W = WORD_W / LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  gbx_mode_e         mode_i,
  input  logic              take_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [LANES-1:0]  data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (take_i) begin
      if (mode_i == GBX_SPLIT) begin
        // lane 0 owns the top slice, last lane the bottom slice
        for (int l = 0; l < LANES; l++) begin
          if (int'(idx_i) < LANE_W)
            stage_d[(LANES-1-l)*LANE_W + int'(idx_i)] = data_i[l];
        end
      end else if (int'(idx_i) < WORD_W) begin
        stage_d[idx_i] = data_i[0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign word_o = stage_d;
endmodule

// File: rtl/gbx_out_reg.sv
module gbx_out_reg
  import gbx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  gbx_mode_e         mode_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] q_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] masked;

  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    if (b == WORD_W - 1) begin : g_top
      assign masked[b] = (mode_i == GBX_NARROW) ? 1'b0 : word_i[b];
    end else begin : g_low
      assign masked[b] = word_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_i;
      if (last_i) q_o <= masked;
    end
  end
endmodule

// File: rtl/gbx_deser.sv
module gbx_deser
  import gbx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [LANES-1:0]  data_i,
  input  logic              slip_i,
  output logic [WORD_W-1:0] q_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  gbx_mode_e         mode;
  logic              take, last;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] word;

  assign mode = gbx_mode_e'(mode_i);

  gbx_word_ctl #(.WORD_W(WORD_W), .LANES(LANES)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .slip_i(slip_i),
    .take_o(take), .last_o(last), .idx_o(idx)
  );

  gbx_stage #(.WORD_W(WORD_W), .LANES(LANES)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .take_i(take),
    .idx_i(idx), .data_i(data_i), .word_o(word)
  );

  gbx_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .last_i(last),
    .word_i(word), .q_o(q_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/gbx_deser_chk.sv
module gbx_deser_chk #(
  parameter int WORD_W = 8,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [LANES-1:0]  data_i,
  input logic              slip_i,
  input logic [WORD_W-1:0] q_o,
  input logic              valid_o
);
  logic [7:0] gap_q, len, exp_gap;
  logic       slip_seen_q, have_prev_q;

  always_comb begin
    case (mode_i)
      2'd0:    len = 8'(WORD_W - 1);
      2'd2:    len = 8'(WORD_W / LANES);
      default: len = 8'(WORD_W);
    endcase
    exp_gap = len + {7'd0, slip_seen_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      slip_seen_q <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (valid_o) begin
      gap_q       <= 8'd1;
      slip_seen_q <= slip_i;
      have_prev_q <= 1'b1;
    end else begin
      if (gap_q != 8'hff) gap_q <= gap_q + 8'd1;
      slip_seen_q <= slip_seen_q | slip_i;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                                          // R4
  AST_Q_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> valid_o);                                     // R4
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> !q_o[WORD_W-1]);                           // R2
  AST_WORD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && have_prev_q) |-> (gap_q == exp_gap));               // R5
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !valid_o));                           // R7
endmodule

bind gbx_deser gbx_deser_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (.*);

// File: tb/gbx_deser_tb.sv
module gbx_deser_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic [1:0] data_i = 2'b00;
  logic       slip_i = 1'b0;
  logic [7:0] q_o;
  logic       valid_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit   qa[$], qb[$];
  bit   blk;
  logic [7:0] exp_q;
  logic       exp_v;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gbx_deser u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .data_i(data_i),
    .slip_i(slip_i), .q_o(q_o), .valid_o(valid_o)
  );

  function automatic int ratio(input logic [1:0] m);
    if (m == 2'd0) return 7;
    if (m == 2'd2) return 4;
    return 8;
  endfunction

  task automatic compare(input string req);
    n_cmp++;
    if (q_o !== exp_q || valid_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: q_o=%h valid_o=%b expected q_o=%h valid_o=%b",
               req, q_o, valid_o, exp_q, exp_v);
    end
  endtask

  task automatic model_edge();
    exp_v = 1'b0;
    if (slip_i && !blk) begin
      blk = 1'b1;
    end else begin
      qa.push_back(data_i[0]);
      qb.push_back(data_i[1]);
      if (qa.size() == ratio(mode_i)) begin
        exp_q = '0;
        for (int i = 0; i < qa.size(); i++) begin
          if (mode_i == 2'd2) begin
            exp_q[4+i] = qa[i];
            exp_q[i]   = qb[i];
          end else begin
            exp_q[i] = qa[i];
          end
        end
        exp_v = 1'b1;
        blk   = 1'b0;
        qa.delete();
        qb.delete();
      end
    end
  endtask

  // called at a falling edge
  task automatic step(input logic [1:0] d, input logic s, input string req);
    data_i = d;
    slip_i = s;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_ni = 1'b0;
    mode_i = m;
    data_i = 2'b11;
    slip_i = 1'b1;
    qa.delete();
    qb.delete();
    blk = 1'b0;
    exp_q = '0;
    exp_v = 1'b0;
    repeat (2) @(negedge clk_i);
    compare("R7 reset");
    slip_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic run_random(input int n, input int slip_pct, input string req);
    for (int i = 0; i < n; i++)
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 99) < slip_pct), req);
  endtask

  initial begin
    @(negedge clk_i);
    do_reset(2'd1);
    // R7: first strobe only after a full word
    for (int i = 0; i < 8; i++) step(2'($urandom_range(0, 3)), 1'b0, "R7 first word");
    run_random(200, 0, "R1 R4 R9 wide");
    // fixed patterns, R1
    for (int i = 0; i < 8; i++) step({1'b1, 1'(i == 0)}, 1'b0, "R1 first bit low");
    for (int i = 0; i < 8; i++) step({1'b0, 1'(i == 7)}, 1'b0, "R1 last bit high");

    do_reset(2'd0);
    run_random(210, 0, "R2 R9 narrow");
    for (int i = 0; i < 14; i++) step(2'b11, 1'b0, "R2 all ones");

    do_reset(2'd2);
    run_random(200, 0, "R3 split");
    for (int i = 0; i < 8; i++) step({1'(i % 2), 1'(i == 0)}, 1'b0, "R3 lane map");

    // slips at each counter phase, and back-to-back pairs (R5, R6)
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      for (int ph = 0; ph < 9; ph++) begin
        for (int i = 0; i < ph; i++) step(2'($urandom_range(0, 3)), 1'b0, "R5 lead");
        step(2'($urandom_range(0, 3)), 1'b1, "R5 slip");
        step(2'($urandom_range(0, 3)), 1'b1, "R6 ignored slip");
        for (int i = 0; i < 3; i++) step(2'($urandom_range(0, 3)), 1'b0, "R6 tail");
        step(2'($urandom_range(0, 3)), 1'b1, "R6 spaced slip");
        for (int i = 0; i < 10; i++) step(2'($urandom_range(0, 3)), 1'b0, "R5 settle");
      end
      run_random(150, 25, "R5 R6 random slips");
    end

    do_reset(2'd3);
    run_random(200, 10, "R8 reserved code");

    // reset in mid-word, then R7 again
    do_reset(2'd1);
    for (int i = 0; i < 5; i++) step(2'b01, 1'b0, "R7 partial");
    do_reset(2'd1);
    for (int i = 0; i < 9; i++) step(2'($urandom_range(0, 3)), 1'b0, "R7 after mid reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule